// File: doc/BRIEF.md
# Multi-Mode 8-bit Timer with Compare Output

An 8-bit count register advances once per tick from a fixed-ratio clock divider. One counter datapath serves four behaviours picked by a 2-bit mode field: a free-running upward count that wraps, a count that returns to zero when it equals the compare value, a single-slope PWM whose top is 0xFF, and a dual-slope PWM that climbs from 0 to 0xFF and falls back to 0.

Two sticky event flags, overflow and compare, each raise an interrupt request when their own enable and a global enable are both high. An acknowledge strobe clears a flag only while its request is asserted. A registered waveform pin reacts to compare events according to a 2-bit action field. In the PWM modes, compare writes go to a shadow register and reach the active compare value only at the top of the count. This keeps each PWM period free of glitches.

Top module: `timer_unit`

## Requirements
- R1: Clock select codes 001, 010, 011, 100 and 101 advance the counter once every 1, 8, 64, 256 and 1024 clocks. Code 000 (and 110, 111) stops it, and the count holds.
- R2: Mode 00 (normal) counts up and wraps from 0xFF to 0x00. The overflow flag is set on the same clock edge at which the counter becomes 0x00.
- R3: Mode 10 (clear on compare): a tick while the count equals the active compare value loads 0 and sets the compare flag, so the cycle length is compare+1 ticks.
- R4: Each flag stays set until its clear strobe is seen on a clock edge. A new event in the same cycle as a clear wins.
- R5: An interrupt output equals flag AND its enable AND the global enable. An acknowledge clears the flag only while that interrupt output is high.
- R6: In modes 00 and 10, a compare event changes the wave pin by action code: 01 toggles, 10 drives 0, 11 drives 1, and 00 holds it.
- R7: Mode 11 (fast PWM, top 0xFF, period 256 ticks): action 10 drives 0 on a compare event and 1 on the wrap to 0. Action 11 is the inverse. When both events fall on the same tick, the wrap action wins, so with compare 40 and action 10 the pin is high 41 of every 256 ticks.
- R8: Mode 01 (phase-correct PWM) counts 0 up to 0xFF and back down, with a period of 510 ticks. Action 10 drives 0 on an upward match and 1 on a downward match. Action 11 is the inverse. The overflow flag is set when the count reaches 0.
- R9: If the compare value is below the current count, no compare event occurs until the counter has wrapped past 0xFF and reaches that value.
- R10: In modes 00 and 10 a compare write takes effect on the next edge. In modes 01 and 11 it takes effect at the tick that leaves 0xFF. The active compare value is visible on cmp_o.
- R11: A counter write loads the count on the next edge and overrides that cycle's tick, with no flag or pin event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Counting mode code |
| clk_sel_i | input | 3 | Divider select code |
| out_act_i | input | 2 | Wave pin action on compare events |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| cmp_ie_i | input | 1 | Compare interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 8 | Counter write value |
| cmp_we_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | 8 | Compare write value |
| ovf_clr_i | input | 1 | Overflow flag clear strobe |
| cmp_clr_i | input | 1 | Compare flag clear strobe |
| ovf_ack_i | input | 1 | Overflow interrupt acknowledge |
| cmp_ack_i | input | 1 | Compare interrupt acknowledge |
| cnt_o | output | 8 | Current count |
| cmp_o | output | 8 | Active compare value |
| ovf_flag_o | output | 1 | Overflow flag |
| cmp_flag_o | output | 1 | Compare flag |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| cmp_irq_o | output | 1 | Compare interrupt request |
| wave_o | output | 1 | Waveform output pin |

## Verification
A wrong direction bit or a wrong wrap point shows at the ports within one tick: cnt_o takes a wrong value, and the duty count measured over a whole PWM period is off. A shadow compare value that is copied at the wrong moment shows on cmp_o at the first tick that leaves 0xFF. A mis-set flag is seen on the edge of the event, because flags and count change together. Divider errors only show as wrong spacing between compare events, up to 1024 clocks per tick, so each divider code is timed across two consecutive pin edges.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_PHASE  = 2'b01,
    MODE_CTC    = 2'b10,
    MODE_FAST   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } act_e;
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int PRE_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             run;

  always_comb begin
    run  = 1'b1;
    mask = '0;
    unique case (sel_i)
      3'd1: mask = PRE_W'((1 << 0) - 1);
      3'd2: mask = PRE_W'((1 << 3) - 1);
      3'd3: mask = PRE_W'((1 << 6) - 1);
      3'd4: mask = PRE_W'((1 << 8) - 1);
      3'd5: mask = PRE_W'((1 << 10) - 1);
      default: run = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;

  assign tick_o = run && ((pre_q & mask) == mask);
endmodule

// File: rtl/timer_counter.sv
module timer_counter
  import timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  mode_e            mode_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             down_o,
  output logic             match_o,
  output logic             bottom_o,
  output logic             ovf_evt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, buf_q, buf_d, eff_q, eff_d;
  logic             dir_q, dir_d;
  logic             adv, pwm, at_top;

  assign adv     = tick_i && !cnt_we_i;
  assign pwm     = (mode_i == MODE_FAST) || (mode_i == MODE_PHASE);
  assign at_top  = cnt_q == CNT_MAX;
  assign match_o = adv && (cnt_q == eff_q);
  assign bottom_o = adv && (mode_i == MODE_FAST) && at_top;
  assign ovf_evt_o = adv && ((mode_i == MODE_PHASE) ? (dir_q && cnt_q == CNT_ONE) : at_top);

  always_comb begin
    cnt_d = cnt_q;
    dir_d = (mode_i == MODE_PHASE) ? dir_q : 1'b0;
    if (cnt_we_i) cnt_d = cnt_wdata_i;
    else if (tick_i) begin
      unique case (mode_i)
        MODE_CTC:   cnt_d = match_o ? '0 : cnt_q + 1'b1;
        MODE_PHASE: begin
          if (!dir_q) begin
            if (at_top) begin dir_d = 1'b1; cnt_d = cnt_q - 1'b1; end
            else cnt_d = cnt_q + 1'b1;
          end else begin
            if (cnt_q == '0) begin dir_d = 1'b0; cnt_d = CNT_ONE; end
            else cnt_d = cnt_q - 1'b1;
          end
        end
        default:    cnt_d = cnt_q + 1'b1;
      endcase
    end
  end

  // shadow compare: direct in non-PWM modes, copied at top in PWM modes
  always_comb begin
    buf_d = cmp_we_i ? cmp_wdata_i : buf_q;
    eff_d = eff_q;
    if (cmp_we_i && !pwm)           eff_d = cmp_wdata_i;
    else if (pwm && adv && at_top)  eff_d = buf_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      buf_q <= '0;
      eff_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      buf_q <= buf_d;
      eff_q <= eff_d;
    end

  assign cnt_o  = cnt_q;
  assign cmp_o  = eff_q;
  assign down_o = dir_q;
endmodule

// File: rtl/timer_flag.sv
module timer_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_i,
  input  logic ie_i,
  input  logic gie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  assign irq_o  = flag_q && ie_i && gie_i;
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                       flag_q <= 1'b0;
    else if (set_i)                    flag_q <= 1'b1;
    else if (clr_i || (ack_i && irq_o)) flag_q <= 1'b0;
endmodule

// File: rtl/timer_wave.sv
module timer_wave
  import timer_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  act_e  act_i,
  input  logic  match_i,
  input  logic  bottom_i,
  input  logic  down_i,
  output logic  wave_o
);
  logic wave_q, wave_d;

  always_comb begin
    wave_d = wave_q;
    unique case (mode_i)
      MODE_FAST: begin
        if (bottom_i) begin
          if (act_i == ACT_CLEAR)    wave_d = 1'b1;
          else if (act_i == ACT_SET) wave_d = 1'b0;
        end else if (match_i) begin
          if (act_i == ACT_CLEAR)    wave_d = 1'b0;
          else if (act_i == ACT_SET) wave_d = 1'b1;
        end
      end
      MODE_PHASE: begin
        if (match_i) begin
          if (act_i == ACT_CLEAR)    wave_d = down_i;
          else if (act_i == ACT_SET) wave_d = !down_i;
        end
      end
      default: begin
        if (match_i) begin
          unique case (act_i)
            ACT_TOGGLE: wave_d = !wave_q;
            ACT_CLEAR:  wave_d = 1'b0;
            ACT_SET:    wave_d = 1'b1;
            default:    wave_d = wave_q;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) wave_q <= 1'b0;
    else         wave_q <= wave_d;

  assign wave_o = wave_q;
endmodule

// File: rtl/timer_unit.sv
module timer_unit
  import timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [2:0]       clk_sel_i,
  input  logic [1:0]       out_act_i,
  input  logic             ovf_ie_i,
  input  logic             cmp_ie_i,
  input  logic             gie_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             ovf_clr_i,
  input  logic             cmp_clr_i,
  input  logic             ovf_ack_i,
  input  logic             cmp_ack_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             ovf_flag_o,
  output logic             cmp_flag_o,
  output logic             ovf_irq_o,
  output logic             cmp_irq_o,
  output logic             wave_o
);
  localparam int N_FLAG = 2;

  mode_e mode;
  logic  tick, down, match, bottom, ovf_evt;
  logic [N_FLAG-1:0] f_set, f_clr, f_ack, f_ie, f_flag, f_irq;

  assign mode = mode_e'(mode_i);

  timer_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .sel_i(clk_sel_i), .tick_o(tick)
  );

  timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .mode_i(mode),
    .cnt_we_i, .cnt_wdata_i, .cmp_we_i, .cmp_wdata_i,
    .cnt_o, .cmp_o, .down_o(down), .match_o(match),
    .bottom_o(bottom), .ovf_evt_o(ovf_evt)
  );

  // index 0: overflow, index 1: compare
  assign f_set = {match, ovf_evt};
  assign f_clr = {cmp_clr_i, ovf_clr_i};
  assign f_ack = {cmp_ack_i, ovf_ack_i};
  assign f_ie  = {cmp_ie_i, ovf_ie_i};

  for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
    timer_flag u_flag (
      .clk_i, .rst_ni, .set_i(f_set[i]), .clr_i(f_clr[i]), .ack_i(f_ack[i]),
      .ie_i(f_ie[i]), .gie_i, .flag_o(f_flag[i]), .irq_o(f_irq[i])
    );
  end

  assign ovf_flag_o = f_flag[0];
  assign cmp_flag_o = f_flag[1];
  assign ovf_irq_o  = f_irq[0];
  assign cmp_irq_o  = f_irq[1];

  timer_wave u_wave (
    .clk_i, .rst_ni, .mode_i(mode), .act_i(act_e'(out_act_i)),
    .match_i(match), .bottom_i(bottom), .down_i(down), .wave_o
  );
endmodule

// File: rtl/timer_unit_chk.sv
module timer_unit_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic [2:0]       clk_sel_i,
  input logic             cnt_we_i,
  input logic [CNT_W-1:0] cnt_wdata_i,
  input logic             cmp_clr_i,
  input logic             cmp_ack_i,
  input logic             ovf_ack_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] cmp_o,
  input logic             ovf_flag_o,
  input logic             cmp_flag_o,
  input logic             ovf_irq_o,
  input logic             cmp_irq_o,
  input logic             tick,
  input logic             ovf_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_stop_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i == 3'd0 && !cnt_we_i) |=> cnt_o == $past(cnt_o));

  p_ovf_at_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag_o) |-> cnt_o == '0);

  p_ctc_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && tick && !cnt_we_i && cnt_o == cmp_o) |=> (cnt_o == '0 && cmp_flag_o));

  p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_flag_o && !cmp_clr_i && !(cmp_ack_i && cmp_irq_o)) |=> cmp_flag_o);

  p_ack_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_irq_o && ovf_ack_i && !ovf_evt) |=> !ovf_flag_o);

  p_shadow_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 2'b11 || mode_i == 2'b01) && !(tick && !cnt_we_i && cnt_o == CNT_MAX))
      |=> $stable(cmp_o));

  p_count_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_o == $past(cnt_wdata_i));
endmodule

bind timer_unit timer_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .clk_sel_i(clk_sel_i),
  .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i), .cmp_clr_i(cmp_clr_i),
  .cmp_ack_i(cmp_ack_i), .ovf_ack_i(ovf_ack_i), .cnt_o(cnt_o), .cmp_o(cmp_o),
  .ovf_flag_o(ovf_flag_o), .cmp_flag_o(cmp_flag_o), .ovf_irq_o(ovf_irq_o),
  .cmp_irq_o(cmp_irq_o), .tick(tick), .ovf_evt(ovf_evt)
);

// File: tb/timer_unit_test.sv
`timescale 1ns/1ps
module timer_unit_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [2:0] clk_sel = 3'd0;
  logic [1:0] act = 2'b00;
  logic       ovf_ie = 1'b0, cmp_ie = 1'b0, gie = 1'b0;
  logic       cnt_we = 1'b0, cmp_we = 1'b0;
  logic [7:0] cnt_wd = '0, cmp_wd = '0;
  logic       ovf_clr = 1'b0, cmp_clr = 1'b0, ovf_ack = 1'b0, cmp_ack = 1'b0;
  logic [7:0] cnt, cmpv;
  logic       ovf_flag, cmp_flag, ovf_irq, cmp_irq, wave;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  timer_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .clk_sel_i(clk_sel), .out_act_i(act),
    .ovf_ie_i(ovf_ie), .cmp_ie_i(cmp_ie), .gie_i(gie),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wd), .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_wd),
    .ovf_clr_i(ovf_clr), .cmp_clr_i(cmp_clr), .ovf_ack_i(ovf_ack), .cmp_ack_i(cmp_ack),
    .cnt_o(cnt), .cmp_o(cmpv), .ovf_flag_o(ovf_flag), .cmp_flag_o(cmp_flag),
    .ovf_irq_o(ovf_irq), .cmp_irq_o(cmp_irq), .wave_o(wave)
  );

  // {compare value, clock select, expected clocks between wave edges}
  localparam int TBL [7][3] = '{
    '{0, 1, 1}, '{3, 1, 4}, '{9, 2, 80}, '{2, 3, 192},
    '{1, 4, 512}, '{0, 5, 1024}, '{200, 1, 201}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic edge_gap(output int gap);
    logic prev;
    int   n;
    n = 0;
    prev = wave;
    while (wave == prev && n < 5000) begin @(negedge clk); n++; end
    prev = wave;
    gap = 0;
    while (n < 10000) begin
      @(negedge clk); gap++; n++;
      if (wave != prev) break;
    end
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wave) hi++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int gap, hi, k;
    step(3);
    rst_ni = 1'b1;
    step(1);
    // reset state
    check(cnt == 0 && cmpv == 0, "R2 reset count", cnt, 0);
    check(!ovf_flag && !cmp_flag && !wave && !ovf_irq && !cmp_irq, "R4 reset flags", ovf_flag, 0);

    // R11 load, R2 wrap and overflow timing
    cnt_we = 1'b1; cnt_wd = 8'hFD;
    step(1);
    check(cnt == 8'hFD, "R11 counter load", cnt, 8'hFD);
    cnt_we = 1'b0; clk_sel = 3'd1;
    step(2);
    check(cnt == 8'hFF && !ovf_flag, "R2 before wrap", cnt, 8'hFF);
    step(1);
    check(cnt == 8'h00 && ovf_flag, "R2 wrap sets overflow", {ovf_flag, cnt}, 256);
    clk_sel = 3'd0;
    step(5);
    check(cnt == 0, "R1 stopped count holds", cnt, 0);
    check(ovf_flag, "R4 flag sticky", ovf_flag, 1);
    ovf_clr = 1'b1;
    step(1);
    ovf_clr = 1'b0;
    check(!ovf_flag, "R4 clear strobe", ovf_flag, 0);

    // R5 interrupt gating and acknowledge
    cnt_we = 1'b1; cnt_wd = 8'hFF;
    step(1);
    cnt_we = 1'b0; clk_sel = 3'd1;
    step(1);
    clk_sel = 3'd0; ovf_ie = 1'b1;
    check(ovf_flag && !ovf_irq, "R5 global enable off", ovf_irq, 0);
    ovf_ack = 1'b1;
    step(1);
    check(ovf_flag, "R5 ack ignored without request", ovf_flag, 1);
    ovf_ack = 1'b0; gie = 1'b1;
    step(1);
    check(ovf_irq, "R5 request raised", ovf_irq, 1);
    ovf_ack = 1'b1;
    step(1);
    ovf_ack = 1'b0;
    check(!ovf_flag && !ovf_irq, "R5 ack clears", ovf_flag, 0);
    gie = 1'b0; ovf_ie = 1'b0;

    // R9 compare below count, R3 clear on match
    mode = 2'b10; cmp_we = 1'b1; cmp_wd = 8'd50; cnt_we = 1'b1; cnt_wd = 8'd100;
    cmp_clr = 1'b1;
    step(1);
    cmp_we = 1'b0; cnt_we = 1'b0; cmp_clr = 1'b0; clk_sel = 3'd1;
    step(206);
    check(cnt == 50 && !cmp_flag, "R9 no match before wrap", cnt, 50);
    step(1);
    check(cnt == 0 && cmp_flag, "R3 match clears and flags", cnt, 0);

    // R1 and R3: divider ratios and compare periods via toggling pin
    for (int i = 0; i < 7; i++) begin
      act = 2'b01; clk_sel = 3'(TBL[i][1]);
      cmp_we = 1'b1; cmp_wd = 8'(TBL[i][0]); cnt_we = 1'b1; cnt_wd = 8'd0;
      step(1);
      cmp_we = 1'b0; cnt_we = 1'b0;
      edge_gap(gap);
      check(gap == TBL[i][2], "R1 R3 toggle spacing", gap, TBL[i][2]);
    end

    // R6 set, clear and hold actions
    clk_sel = 3'd1; cmp_we = 1'b1; cmp_wd = 8'd3;
    act = 2'b10;
    step(1);
    cmp_we = 1'b0;
    step(10);
    check(!wave, "R6 clear action", wave, 0);
    act = 2'b11;
    step(10);
    check(wave, "R6 set action", wave, 1);
    act = 2'b00;
    step(20);
    check(wave, "R6 hold action", wave, 1);

    // R10 shadowed compare in fast PWM
    clk_sel = 3'd0; mode = 2'b11; act = 2'b10;
    cmp_we = 1'b1; cmp_wd = 8'd40; cnt_we = 1'b1; cnt_wd = 8'hFE;
    step(1);
    cmp_we = 1'b0; cnt_we = 1'b0;
    check(cmpv == 3, "R10 write held in shadow", cmpv, 3);
    clk_sel = 3'd1;
    step(1);
    check(cnt == 8'hFF && cmpv == 3, "R10 not before top", cmpv, 3);
    step(1);
    check(cnt == 0 && cmpv == 40, "R10 copied at top", cmpv, 40);

    // R7 fast PWM duty
    step(300);
    count_high(256, hi);
    check(hi == 41, "R7 duty clear-on-match", hi, 41);
    act = 2'b11;
    step(300);
    count_high(256, hi);
    check(hi == 215, "R7 duty set-on-match", hi, 215);
    act = 2'b10; cmp_we = 1'b1; cmp_wd = 8'hFF;
    step(1);
    cmp_we = 1'b0;
    step(600);
    count_high(256, hi);
    check(hi == 256, "R7 bottom wins at 0xFF", hi, 256);

    // R8 phase-correct PWM
    mode = 2'b01; cmp_we = 1'b1; cmp_wd = 8'd100;
    step(1);
    cmp_we = 1'b0;
    step(1200);
    count_high(510, hi);
    check(hi == 200, "R8 dual-slope duty", hi, 200);
    act = 2'b11;
    step(600);
    count_high(510, hi);
    check(hi == 310, "R8 dual-slope inverted", hi, 310);
    ovf_clr = 1'b1;
    step(1);
    ovf_clr = 1'b0;
    k = 0;
    while (!ovf_flag && k < 600) begin step(1); k++; end
    check(ovf_flag && cnt == 0, "R8 overflow at bottom", cnt, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule